// File: doc/BRIEF.md
# Auto-Incrementing Register Write Port

This block sits between a command processor's move instructions and the chip's register bus. The processor issues commands of three kinds. Two of them load a register address: the trusted kind is never checked, and the user kind is compared against a small protection table. The third kind carries a data word. Each data word becomes one (address, data) transfer on a valid/ready output bus. After each transfer the address advances, so a run of data words fills a run of consecutive registers.

The address is 32 bits wide and holds three fields:
- Bits 17:0 are the register offset, which is the part that advances.
- Bit 18 freezes the address, so repeated data words all land on one register.
- Bits 31:24 select the write-only pipe-register space when they are nonzero.

Two pipe codes, 0x84 and 0x85, carry no data. Loading an address with either code issues a transfer at once, with zero data.

A user address whose offset falls inside a protected window raises `fault`. Every data word is then discarded until the next address load that passes.

Control is a four-state machine:
- `ST_IDLE` is the state after reset, before any address is held.
- `ST_ARMED` holds a valid address.
- `ST_SEND` holds one transfer until the bus takes it.
- `ST_FAULT` follows a rejected user address.

Transitions:
- A passing load moves `ST_IDLE`, `ST_ARMED` or `ST_FAULT` to `ST_ARMED`. It goes to `ST_SEND` instead when the code is data-less.
- A rejected user load moves any of those three states to `ST_FAULT`.
- A data word moves `ST_ARMED` to `ST_SEND`.
- `wr_ready` moves `ST_SEND` back to `ST_ARMED`.

Top module: `regwr_port`

## Requirements
- R1: After reset `wr_valid` and `fault` are low and `in_ready` is high.
- R2: A data word (`in_kind` = 0) accepted while an address is held produces one transfer. The transfer carries the held address and that word. The offset field (bits 17:0) then advances by one, wrapping within those 18 bits. Bits 31:18 are left unchanged.
- R3: While bit 18 of the held address is 1, the address does not change across data words.
- R4: A pending transfer keeps `wr_valid`, `wr_addr` and `wr_data` steady until `wr_ready` is high. `in_ready` is low for as long as a transfer is pending, so no command is taken and the held address does not move.
- R5: A trusted address load (`in_kind` = 1) never raises `fault` and clears any earlier fault.
- R6: The default protection table has three active windows. A user load (`in_kind` = 2) whose offset falls inside one of them sets `fault`, and data words are then discarded with no transfer. The windows are:
  - 0x100 to 0x10F
  - 0x800 to 0x803
  - 0x2000 to 0x20FF
- R7: A user load whose offset lies outside every window behaves exactly like a trusted load.
- R8: `wr_pipe` is high on a transfer exactly when bits 31:24 of its address are nonzero.
- R9: A passing load whose bits 31:24 equal 0x84 or 0x85 issues a transfer in the next cycle. That transfer has the loaded address, zero data and `wr_pipe` high, and it leaves the held address unchanged. A rejected user load issues nothing.
- R10: Data words taken before any address load, and commands of the reserved kind (`in_kind` = 3), are accepted and produce no transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Command present |
| in_ready | output | 1 | Command taken this cycle when in_valid is high |
| in_kind | input | 2 | 0 data, 1 trusted address, 2 user address, 3 reserved |
| in_value | input | 32 | Data word or address |
| wr_valid | output | 1 | Transfer pending |
| wr_ready | input | 1 | Bus takes the transfer |
| wr_addr | output | 32 | Transfer address |
| wr_data | output | 32 | Transfer data |
| wr_pipe | output | 1 | Transfer targets pipe-register space |
| fault | output | 1 | Last address load was rejected |

## Verification
The assertions check the following on every cycle:
- The output handshake holds steady while it stalls, and input is blocked while a transfer is pending.
- No transfer appears while `fault` is high.
- A trusted load always clears `fault`, and a reserved command produces no transfer.
- A trusted load of a data-less pipe code fires at once with zero data.

Three behaviours can only be shown by the bench's scenarios, against a reference model that tracks the held address:
- the sequence of advancing addresses and their wrap;
- the frozen address under bit 18;
- the exact edges of each protection window.

// File: rtl/regwr_pkg.sv
package regwr_pkg;
    typedef enum logic [1:0] {
        K_DATA    = 2'd0,
        K_TRUSTED = 2'd1,
        K_USER    = 2'd2,
        K_NONE    = 2'd3
    } cmd_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ARMED,
        ST_SEND,
        ST_FAULT
    } state_e;
endpackage

// File: rtl/prot_check.sv
module prot_check #(
    parameter int                    NENT = 4,
    parameter int                    OFFW = 18,
    parameter logic [NENT*OFFW-1:0]  BASES = '0,
    parameter logic [NENT*OFFW-1:0]  LENS  = '0
) (
    input  logic [OFFW-1:0] off,
    output logic            hit
);
    logic [NENT-1:0] win_hit;

    for (genvar i = 0; i < NENT; i++) begin : g_win
        localparam logic [OFFW:0] LO = {1'b0, BASES[i*OFFW +: OFFW]};
        localparam logic [OFFW:0] HI = LO + {1'b0, LENS[i*OFFW +: OFFW]};
        assign win_hit[i] = ({1'b0, off} >= LO) && ({1'b0, off} < HI);
    end

    assign hit = |win_hit;
endmodule

// File: rtl/pipe_fire_decode.sv
module pipe_fire_decode #(
    parameter int                 CODE_W    = 8,
    parameter logic [CODE_W-1:0]  DL_CODE_A = 8'h84,
    parameter logic [CODE_W-1:0]  DL_CODE_B = 8'h85
) (
    input  logic [CODE_W-1:0] code,
    output logic              fires
);
    assign fires = (code == DL_CODE_A) || (code == DL_CODE_B);
endmodule

// File: rtl/addr_step.sv
module addr_step #(
    parameter int AW        = 32,
    parameter int NOINC_BIT = 18
) (
    input  logic [AW-1:0] cur,
    output logic [AW-1:0] nxt
);
    always_comb begin
        if (cur[NOINC_BIT]) begin
            nxt = cur;
        end else begin
            nxt = {cur[AW-1:NOINC_BIT], cur[NOINC_BIT-1:0] + NOINC_BIT'(1)};
        end
    end
endmodule

// File: rtl/regwr_port.sv
module regwr_port
    import regwr_pkg::*;
#(
    parameter int                       AW        = 32,
    parameter int                       CODE_W    = 8,
    parameter int                       NOINC_BIT = 18,
    parameter int                       NENT      = 4,
    parameter logic [NENT*NOINC_BIT-1:0] PROT_BASE =
        {18'h00000, 18'h02000, 18'h00800, 18'h00100},
    parameter logic [NENT*NOINC_BIT-1:0] PROT_LEN  =
        {18'h00000, 18'h00100, 18'h00004, 18'h00010},
    parameter logic [CODE_W-1:0]        DL_CODE_A = 8'h84,
    parameter logic [CODE_W-1:0]        DL_CODE_B = 8'h85
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [1:0]    in_kind,
    input  logic [AW-1:0] in_value,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] wr_data,
    output logic          wr_pipe,
    output logic          fault
);
    localparam int OFFW = NOINC_BIT;

    state_e        state, state_n;
    cmd_kind_e     kind;
    logic [AW-1:0] cur_addr, cur_next;
    logic [AW-1:0] wr_addr_q, wr_data_q;
    logic          accept, load, data_take, viol, in_hit, in_fires;

    prot_check #(
        .NENT (NENT), .OFFW (OFFW), .BASES (PROT_BASE), .LENS (PROT_LEN)
    ) u_prot (
        .off (in_value[OFFW-1:0]),
        .hit (in_hit)
    );

    pipe_fire_decode #(
        .CODE_W (CODE_W), .DL_CODE_A (DL_CODE_A), .DL_CODE_B (DL_CODE_B)
    ) u_fire (
        .code  (in_value[AW-1 -: CODE_W]),
        .fires (in_fires)
    );

    addr_step #(.AW (AW), .NOINC_BIT (NOINC_BIT)) u_step (
        .cur (cur_addr),
        .nxt (cur_next)
    );

    assign kind      = cmd_kind_e'(in_kind);
    assign in_ready  = (state != ST_SEND);
    assign accept    = in_valid && in_ready;
    assign load      = accept && ((kind == K_TRUSTED) || (kind == K_USER));
    assign viol      = (kind == K_USER) && in_hit;
    assign data_take = accept && (kind == K_DATA) && (state == ST_ARMED);

    // next-state logic
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE, ST_ARMED, ST_FAULT: begin
                if (load) begin
                    if (viol)          state_n = ST_FAULT;
                    else if (in_fires) state_n = ST_SEND;
                    else               state_n = ST_ARMED;
                end else if (data_take) begin
                    state_n = ST_SEND;
                end
            end
            ST_SEND: begin
                if (wr_ready) state_n = ST_ARMED;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // output and address registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr  <= '0;
            wr_addr_q <= '0;
            wr_data_q <= '0;
        end else if (load) begin
            cur_addr <= in_value;
            if (!viol && in_fires) begin
                wr_addr_q <= in_value;
                wr_data_q <= '0;
            end
        end else if (data_take) begin
            wr_addr_q <= cur_addr;
            wr_data_q <= in_value;
            cur_addr  <= cur_next;
        end
    end

    assign wr_valid = (state == ST_SEND);
    assign fault    = (state == ST_FAULT);
    assign wr_addr  = wr_addr_q;
    assign wr_data  = wr_data_q;
    assign wr_pipe  = |wr_addr_q[AW-1 -: CODE_W];
endmodule

// File: rtl/regwr_port_chk.sv
module regwr_port_chk #(
    parameter int                AW        = 32,
    parameter int                CODE_W    = 8,
    parameter logic [CODE_W-1:0] DL_CODE_A = 8'h84,
    parameter logic [CODE_W-1:0] DL_CODE_B = 8'h85
) (
    input logic          clk,
    input logic          rst_n,
    input logic          in_valid,
    input logic          in_ready,
    input logic [1:0]    in_kind,
    input logic [AW-1:0] in_value,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [AW-1:0] wr_addr,
    input logic [AW-1:0] wr_data,
    input logic          fault
);
    // R4
    hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_addr) && $stable(wr_data));

    // R4
    busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> !in_ready);

    // R6
    fault_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !wr_valid);

    // R5
    trusted_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_kind == 2'd1 |=> !fault);

    // R10
    reserved_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_kind == 2'd3 |=> !wr_valid);

    // R9
    pipe_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_kind == 2'd1 &&
        (in_value[AW-1 -: CODE_W] == DL_CODE_A || in_value[AW-1 -: CODE_W] == DL_CODE_B)
        |=> wr_valid && wr_data == '0 && wr_addr == $past(in_value));
endmodule

bind regwr_port regwr_port_chk #(
    .AW (AW), .CODE_W (CODE_W), .DL_CODE_A (DL_CODE_A), .DL_CODE_B (DL_CODE_B)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_kind  (in_kind),
    .in_value (in_value),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .fault    (fault)
);

// File: tb/test_regwr_port.sv
module test_regwr_port;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic        in_ready;
    logic [1:0]  in_kind;
    logic [31:0] in_value;
    logic        wr_valid;
    logic        wr_ready;
    logic [31:0] wr_addr;
    logic [31:0] wr_data;
    logic        wr_pipe;
    logic        fault;

    always #5 clk = ~clk;

    regwr_port i_regwr_port (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_ready (in_ready),
        .in_kind (in_kind), .in_value (in_value), .wr_valid (wr_valid),
        .wr_ready (wr_ready), .wr_addr (wr_addr), .wr_data (wr_data),
        .wr_pipe (wr_pipe), .fault (fault)
    );

    int    total = 0;
    int    bad = 0;
    string cur_req = "R1";
    int    rdy_mode = 0;
    int    rdy_cnt = 0;
    bit    chk_on = 0;

    // reference model state
    bit        m_pend, m_have, m_flt;
    bit [31:0] m_waddr, m_wdata, m_cur;

    function automatic bit in_window(bit [31:0] a);
        int off = int'(a[17:0]);
        return (off >= 'h100 && off < 'h110) || (off >= 'h800 && off < 'h804) ||
               (off >= 'h2000 && off < 'h2100);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_pend = 0; m_have = 0; m_flt = 0;
            m_waddr = 0; m_wdata = 0; m_cur = 0;
        end else begin
            bit acc;
            bit rej;
            acc = in_valid && !m_pend;
            if (m_pend && wr_ready) m_pend = 0;
            if (acc) begin
                if (in_kind == 2'd0) begin
                    if (m_have && !m_flt) begin
                        m_pend  = 1;
                        m_waddr = m_cur;
                        m_wdata = in_value;
                        if (!m_cur[18]) m_cur[17:0] = m_cur[17:0] + 1;
                    end
                end else if (in_kind == 2'd1 || in_kind == 2'd2) begin
                    rej    = (in_kind == 2'd2) && in_window(in_value);
                    m_flt  = rej;
                    m_have = !rej;
                    m_cur  = in_value;
                    if (!rej && (in_value[31:24] == 8'h84 || in_value[31:24] == 8'h85)) begin
                        m_pend  = 1;
                        m_waddr = in_value;
                        m_wdata = 0;
                    end
                end
            end
        end
    end

    task automatic check(input string what, input bit [31:0] act, input bit [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s act=%h exp=%h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && chk_on) begin
            check("wr_valid", 32'(wr_valid), 32'(m_pend));
            check("in_ready", 32'(in_ready), 32'(!m_pend));
            check("fault", 32'(fault), 32'(m_flt));
            if (m_pend) begin
                check("wr_addr", wr_addr, m_waddr);
                check("wr_data", wr_data, m_wdata);
                check("wr_pipe", 32'(wr_pipe), 32'(m_waddr[31:24] != 0));
            end
        end
        rdy_cnt++;
        if (rdy_mode == 0) wr_ready = 1'b1;
        else               wr_ready = (rdy_cnt % 3 == 0);
    end

    task automatic send(input bit [1:0] k, input bit [31:0] v);
        in_kind  = k;
        in_value = v;
        in_valid = 1'b1;
        do @(negedge clk); while (!in_ready);
        @(posedge clk);
        #1 in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic summary;
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL %s watchdog expired act=0 exp=1", cur_req);
        summary();
        $finish;
    end

    initial begin
        rst_n = 0; in_valid = 0; in_kind = 0; in_value = 0; wr_ready = 1;
        idle(3);
        rst_n = 1;
        @(negedge clk);
        cur_req = "R1";
        check("reset wr_valid", 32'(wr_valid), 0);
        check("reset fault", 32'(fault), 0);
        check("reset in_ready", 32'(in_ready), 1);
        chk_on = 1;

        cur_req = "R10";
        send(2'd0, 32'hDEAD0001);
        send(2'd3, 32'h00000050);
        idle(3);

        cur_req = "R2";
        send(2'd1, 32'h00000010);
        for (int i = 0; i < 4; i++) send(2'd0, 32'hA0 + i);
        send(2'd1, 32'h0003FFFE);
        for (int i = 0; i < 3; i++) send(2'd0, 32'hB0 + i);
        idle(2);

        cur_req = "R10";
        send(2'd3, 32'h12345678);
        send(2'd0, 32'hC0);
        idle(2);

        cur_req = "R3";
        send(2'd1, 32'h00040020);
        for (int i = 0; i < 3; i++) send(2'd0, 32'hD0 + i);
        idle(2);

        cur_req = "R4";
        rdy_mode = 1;
        send(2'd1, 32'h00000300);
        for (int i = 0; i < 5; i++) send(2'd0, 32'hE0 + i);
        idle(6);
        rdy_mode = 0;

        cur_req = "R5";
        send(2'd1, 32'h00000105);
        send(2'd0, 32'h11);
        idle(2);

        cur_req = "R6";
        send(2'd2, 32'h00000108);
        send(2'd0, 32'h22);
        send(2'd0, 32'h23);
        send(2'd2, 32'h00000803);
        send(2'd0, 32'h24);
        send(2'd2, 32'h000020FF);
        send(2'd0, 32'h25);
        cur_req = "R5";
        send(2'd1, 32'h000020FF);
        send(2'd0, 32'h26);
        idle(2);

        cur_req = "R7";
        send(2'd2, 32'h00000804);
        send(2'd0, 32'h31);
        send(2'd2, 32'h000000FF);
        send(2'd0, 32'h32);
        send(2'd2, 32'h00000110);
        send(2'd0, 32'h33);
        idle(2);

        cur_req = "R8";
        send(2'd1, 32'h12000040);
        send(2'd0, 32'h41);
        send(2'd0, 32'h42);
        send(2'd1, 32'h86000000);
        idle(2);
        send(2'd0, 32'h43);
        idle(2);

        cur_req = "R9";
        send(2'd2, 32'h84000000);
        idle(2);
        send(2'd0, 32'h51);
        rdy_mode = 1;
        send(2'd1, 32'h85000010);
        idle(4);
        rdy_mode = 0;
        send(2'd2, 32'h84000100);
        idle(3);
        send(2'd0, 32'h52);
        idle(5);

        summary();
        $finish;
    end
endmodule